// File: doc/BRIEF.md
# Streaming Coefficient Dequantizer

This block rebuilds signed transform coefficients from quantized levels, one coefficient per cycle, for an 8x8 block of 64 positions. Each non-zero level is scaled by twice the quantizer step and then pushed away from zero by a rounding offset. The offset depends on the parity of the step: it equals the step when the step is odd and the step minus one when it is even. The result is clamped to a 12-bit signed range. In intra mode the first position of every block is the DC term, and it is scaled by a separate DC scaler instead of the step.

Levels enter on a valid/ready stream and coefficients leave on another. A beat is accepted on any rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. While the output is stalled (`out_valid` high, `out_ready` low), `out_coef` holds its value and no level is taken. An accepted level produces its coefficient one cycle later. The step, DC scaler and mode are sampled when a block's first level is accepted, and they apply to the whole block. `blk_done` marks the end of each block.

Top module: `dqz_dequant`

## Requirements
- R1: A level of zero at any position, including intra position 0, yields a coefficient of exactly zero.
- R2: A positive level c at an AC position with an odd step Q yields min(2Q*c + Q, 2047).
- R3: A positive level c at an AC position with an even step Q yields min(2Q*c + Q - 1, 2047).
- R4: A negative level yields the negated magnitude of the equivalent positive level: -(2Q*|c| + offset). It saturates at -2048 rather than at -2047.
- R5: The product is formed wide enough that a level of 32767 or -32768 saturates to 2047 or -2048 instead of wrapping. No output coefficient ever leaves [-2048, 2047].
- R6: At the boundary with Q=1, a level of 1023 yields 2047, a level of -1023 yields -2047, and a level of -1024 yields -2048.
- R7: With `cfg_intra` high, position 0 yields level times `cfg_dcs`, clamped to [-2048, 2047]. Positions 1..63 follow the AC rule.
- R8: With `cfg_intra` low, position 0 follows the same AC rule as positions 1..63.
- R9: The stream carries one beat per cycle when `out_ready` stays high, with one cycle of latency. When `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_coef` holds its value. Every new `out_valid` follows an accepted input.
- R10: `blk_done` goes high for exactly one cycle, on the cycle after the 64th coefficient of a block is taken downstream.
- R11: `cfg_q`, `cfg_dcs` and `cfg_intra` are captured when position 0 is accepted. Changes to them later in the block have no effect on that block's outputs.
- R12: After reset, `out_valid` and `blk_done` are low, `in_ready` is high, and the next accepted level is position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_intra | input | 1 | 1 = intra block (position 0 uses the DC scaler), 0 = inter block |
| cfg_q | input | 5 | Quantizer step, 1..31 |
| cfg_dcs | input | 6 | DC scaler for intra position 0 |
| in_valid | input | 1 | Level beat valid |
| in_ready | output | 1 | Level beat accepted when high together with in_valid |
| in_level | input | 16 | Signed quantized level |
| out_valid | output | 1 | Coefficient beat valid |
| out_ready | input | 1 | Downstream accepts the coefficient |
| out_coef | output | 16 | Signed reconstructed coefficient, range [-2048, 2047] |
| blk_done | output | 1 | One-cycle pulse after the last coefficient of a block leaves |

## Verification
If the position counter drifts, DC scaling lands on the wrong beat, and the bench sees a wrong value at position 0 or 1 in the very next block. It also sees `blk_done` missing or misplaced one cycle after the 64th transfer. A wrong captured configuration shows up one cycle after the first affected beat as a coefficient computed with the wrong step. A wrong sign or offset path shows up in the value of the first non-zero beat of a block. A lost or duplicated beat under back-pressure shows up as a stall-hold mismatch on the following cycle, or as a misaligned expected queue from then on.

// File: rtl/dqz_pkg.sv
package dqz_pkg;

  localparam int unsigned DQZ_QW  = 5;
  localparam int unsigned DQZ_DCW = 6;

  typedef enum logic {
    DQZ_MODE_INTER = 1'b0,
    DQZ_MODE_INTRA = 1'b1
  } dqz_mode_e;

  typedef struct packed {
    dqz_mode_e               mode;
    logic [DQZ_QW-1:0]       step;
    logic [DQZ_DCW-1:0]      dc_scale;
  } dqz_cfg_t;

endpackage

// File: rtl/dqz_ac_recon.sv
module dqz_ac_recon #(
  parameter int unsigned LW   = 16,
  parameter int unsigned QW   = 5,
  parameter int unsigned OW   = 16,
  parameter int unsigned SATW = 12
) (
  input  logic [LW-1:0] level,
  input  logic [QW-1:0] step,
  output logic [OW-1:0] coef
);
  localparam int unsigned MW = LW + 1;
  localparam int unsigned PW = MW + QW + 1;
  localparam logic [SATW-2:0] MAG_MAX = '1;

  logic            is_neg;
  logic            is_zero;
  logic [MW-1:0]   mag;
  logic [QW:0]     twice_step;
  logic [QW-1:0]   round_off;
  logic [PW-1:0]   product;
  logic [PW-1:0]   biased;
  logic [PW-1:0]   pre_clip;
  logic [SATW-2:0] mag_clip;

  always_comb begin
    is_neg     = level[LW-1];
    is_zero    = (level == '0);
    mag        = is_neg ? (MW'(0) - {level[LW-1], level}) : {1'b0, level};
    twice_step = {step, 1'b0};
    round_off  = step[0] ? step : (step - 1'b1);
    product    = PW'(mag) * PW'(twice_step);
    biased     = product + PW'(round_off);
    // negative path: one less before the clip, inverted afterwards
    pre_clip   = biased - PW'(is_neg);
    mag_clip   = (pre_clip > PW'(MAG_MAX)) ? MAG_MAX : pre_clip[SATW-2:0];
    if (is_zero) begin
      coef = '0;
    end else if (is_neg) begin
      coef = ~(OW'(mag_clip));
    end else begin
      coef = OW'(mag_clip);
    end
  end
endmodule

// File: rtl/dqz_dc_recon.sv
module dqz_dc_recon #(
  parameter int unsigned LW   = 16,
  parameter int unsigned DCW  = 6,
  parameter int unsigned OW   = 16,
  parameter int unsigned SATW = 12
) (
  input  logic [LW-1:0]  level,
  input  logic [DCW-1:0] dc_scale,
  output logic [OW-1:0]  coef
);
  localparam int unsigned PW = LW + DCW + 1;
  localparam logic signed [PW-1:0] LIM_HI = PW'((1 << (SATW - 1)) - 1);
  localparam logic signed [PW-1:0] LIM_LO = -LIM_HI - PW'(1);

  logic signed [PW-1:0] lvl_x;
  logic signed [PW-1:0] scl_x;
  logic signed [PW-1:0] product;

  always_comb begin
    lvl_x   = PW'($signed(level));
    scl_x   = PW'({1'b0, dc_scale});
    product = lvl_x * scl_x;
    if (product > LIM_HI) begin
      coef = LIM_HI[OW-1:0];
    end else if (product < LIM_LO) begin
      coef = LIM_LO[OW-1:0];
    end else begin
      coef = product[OW-1:0];
    end
  end
endmodule

// File: rtl/dqz_ctrl.sv
module dqz_ctrl
  import dqz_pkg::*;
#(
  parameter int unsigned NCOEF = 64,
  localparam int unsigned POSW = $clog2(NCOEF)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  dqz_cfg_t        cfg_in,
  output dqz_cfg_t        cfg_eff,
  output logic            at_first,
  output logic            at_last
);
  localparam logic [POSW-1:0] LAST_POS = POSW'(NCOEF - 1);

  logic [POSW-1:0] pos_q;
  dqz_cfg_t        held_q;

  always_comb begin
    at_first = (pos_q == '0);
    at_last  = (pos_q == LAST_POS);
    cfg_eff  = at_first ? cfg_in : held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      held_q <= '0;
    end else if (accept) begin
      if (at_first) begin
        held_q <= cfg_in;
      end
      pos_q <= at_last ? '0 : pos_q + 1'b1;
    end
  end
endmodule

// File: rtl/dqz_dequant.sv
module dqz_dequant
  import dqz_pkg::*;
#(
  parameter int unsigned LW    = 16,
  parameter int unsigned OW    = 16,
  parameter int unsigned SATW  = 12,
  parameter int unsigned NCOEF = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_intra,
  input  logic [DQZ_QW-1:0]   cfg_q,
  input  logic [DQZ_DCW-1:0]  cfg_dcs,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LW-1:0]       in_level,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [OW-1:0]       out_coef,
  output logic                blk_done
);
  dqz_cfg_t     cfg_in;
  dqz_cfg_t     cfg_eff;
  logic         accept;
  logic         at_first;
  logic         at_last;
  logic [OW-1:0] ac_coef;
  logic [OW-1:0] dc_coef;
  logic          use_dc;
  logic          ovalid_q;
  logic [OW-1:0] ocoef_q;
  logic          olast_q;
  logic          done_q;

  always_comb begin
    cfg_in.mode     = dqz_mode_e'(cfg_intra);
    cfg_in.step     = cfg_q;
    cfg_in.dc_scale = cfg_dcs;
    in_ready        = !ovalid_q || out_ready;
    accept          = in_valid && in_ready;
    use_dc          = at_first && (cfg_eff.mode == DQZ_MODE_INTRA);
  end

  dqz_ctrl #(.NCOEF(NCOEF)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .cfg_in   (cfg_in),
    .cfg_eff  (cfg_eff),
    .at_first (at_first),
    .at_last  (at_last)
  );

  dqz_ac_recon #(.LW(LW), .QW(DQZ_QW), .OW(OW), .SATW(SATW)) u_ac (
    .level (in_level),
    .step  (cfg_eff.step),
    .coef  (ac_coef)
  );

  dqz_dc_recon #(.LW(LW), .DCW(DQZ_DCW), .OW(OW), .SATW(SATW)) u_dc (
    .level    (in_level),
    .dc_scale (cfg_eff.dc_scale),
    .coef     (dc_coef)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovalid_q <= 1'b0;
      ocoef_q  <= '0;
      olast_q  <= 1'b0;
    end else if (accept) begin
      ovalid_q <= 1'b1;
      ocoef_q  <= use_dc ? dc_coef : ac_coef;
      olast_q  <= at_last;
    end else if (out_ready) begin
      ovalid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= ovalid_q && out_ready && olast_q;
    end
  end

  assign out_valid = ovalid_q;
  assign out_coef  = ocoef_q;
  assign blk_done  = done_q;
endmodule

// File: rtl/dqz_dequant_chk.sv
module dqz_dequant_chk #(
  parameter int unsigned LW   = 16,
  parameter int unsigned OW   = 16,
  parameter int unsigned SATW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [LW-1:0] in_level,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_coef,
  input logic          blk_done
);
  localparam int HI = (1 << (SATW - 1)) - 1;
  localparam int LO = -(1 << (SATW - 1));

  p_out_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (($signed(out_coef) <= HI) && ($signed(out_coef) >= LO)));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_coef)));

  p_fresh_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(out_valid)) |-> $past(in_valid && in_ready));

  p_zero_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_level == '0)) |=> (out_coef == '0));

  p_pos_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_level[LW-1]) |=> ($signed(out_coef) >= 0));

  p_neg_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_level[LW-1]) |=> ($signed(out_coef) <= 0));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);
endmodule

bind dqz_dequant dqz_dequant_chk #(.LW(LW), .OW(OW), .SATW(SATW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_level  (in_level),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_coef  (out_coef),
  .blk_done  (blk_done)
);

// File: tb/sim_dqz_dequant.sv
module sim_dqz_dequant;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_intra = 1'b0;
  logic [4:0]  cfg_q = 5'd1;
  logic [5:0]  cfg_dcs = 6'd8;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_level = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_coef;
  logic        blk_done;

  always #4 clk = ~clk;

  dqz_dequant u0 (
    .clk(clk), .rst_n(rst_n), .cfg_intra(cfg_intra), .cfg_q(cfg_q),
    .cfg_dcs(cfg_dcs), .in_valid(in_valid), .in_ready(in_ready),
    .in_level(in_level), .out_valid(out_valid), .out_ready(out_ready),
    .out_coef(out_coef), .blk_done(blk_done)
  );

  typedef struct { int ex; string tag; } exp_t;
  exp_t eq[$];

  int n_chk = 0;
  int n_bad = 0;
  int n_out = 0;
  int waits = 0;
  int cyc = 0;
  bit stall_en = 0;
  bit pend_done = 0;
  bit was_stalled = 0;
  logic [15:0] held_coef = '0;
  bit finished = 0;

  // columns: intra, q, dcs, level, expected pos0, expected pos1
  localparam int NT = 18;
  localparam int TBL [NT][6] = '{
    '{0,  3,  8,     5,    33,    33},
    '{0,  4,  8,     5,    43,    43},
    '{0,  4,  8,    -5,   -43,   -43},
    '{0, 31,  8,   100,  2047,  2047},
    '{0, 31,  8,  -100, -2048, -2048},
    '{0,  1,  8, 32767,  2047,  2047},
    '{0,  1,  8,-32768, -2048, -2048},
    '{0,  2,  8,    -1,    -5,    -5},
    '{1,  5,  8,    10,    80,   105},
    '{1,  6, 13,    -7,   -91,   -89},
    '{1,  1, 46,   100,  2047,   201},
    '{1,  1, 46,  -100, -2048,  -201},
    '{1, 31,  8,     0,     0,     0},
    '{0, 31,  8,    33,  2047,  2047},
    '{0, 16,  8,   -64, -2048, -2048},
    '{0,  1,  8,  1023,  2047,  2047},
    '{0,  1,  8, -1023, -2047, -2047},
    '{0,  1,  8, -1024, -2048, -2048}
  };
  string tags [NT] = '{"R2/R8", "R3", "R4", "R5", "R4", "R5", "R5", "R4",
                        "R7", "R7", "R7", "R7", "R1", "R5", "R4", "R6",
                        "R6", "R6"};

  function automatic int ref_ac(input int q, input int lv);
    int m;
    if (lv == 0) return 0;
    m = (lv < 0 ? -lv : lv) * 2 * q + ((q % 2 == 1) ? q : q - 1);
    if (lv > 0) return (m > 2047) ? 2047 : m;
    return (m > 2048) ? -2048 : -m;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int ex);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, ex);
    end
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  endtask

  // call just after a negedge; returns just after the next negedge
  task automatic send_beat(input int lv, input int ex, input string tg);
    in_valid = 1'b1;
    in_level = lv[15:0];
    while (!in_ready) begin
      waits++;
      @(negedge clk);
    end
    eq.push_back('{ex, tg});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain;
    int guard = 0;
    while ((eq.size() != 0 || out_valid || pend_done) && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    #2;
    if (stall_en) out_ready = ((cyc % 3) != 0);
    else          out_ready = 1'b1;
    if (cyc > 150000) begin
      check(0, "watchdog", cyc, 150000);
      finish_up();
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_done) check(blk_done == 1'b1, "R10 done pulse", blk_done, 1);
      else if (blk_done) check(0, "R10 stray done", 1, 0);
      pend_done = 0;
      if (was_stalled)
        check(out_valid && out_coef == held_coef, "R9 stall hold",
              $signed(out_coef), $signed(held_coef));
      if (out_valid && out_ready) begin
        if (eq.size() == 0) begin
          check(0, "R9 unexpected beat", $signed(out_coef), 0);
        end else begin
          exp_t e;
          e = eq.pop_front();
          check($signed(out_coef) == e.ex, e.tag, $signed(out_coef), e.ex);
        end
        n_out++;
        if (n_out % 64 == 0) pend_done = 1;
      end
      was_stalled = out_valid && !out_ready;
      held_coef = out_coef;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R12 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R12 in_ready", in_ready, 1);
    check(blk_done == 1'b0, "R12 blk_done", blk_done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: each row is one block, levels at positions 0 and 1
    for (int r = 0; r < NT; r++) begin
      cfg_intra = TBL[r][0][0];
      cfg_q     = TBL[r][1][4:0];
      cfg_dcs   = TBL[r][2][5:0];
      waits = 0;
      send_beat(TBL[r][3], TBL[r][4], {tags[r], " pos0"});
      send_beat(TBL[r][3], TBL[r][5], {tags[r], " pos1"});
      for (int p = 2; p < 64; p++) send_beat(0, 0, "R1 zero level");
      drain();
      check(waits == 0, "R9 full throughput", waits, 0);
    end

    // back-pressure with a varied level pattern
    stall_en = 1;
    cfg_intra = 1'b0; cfg_q = 5'd7;
    for (int p = 0; p < 64; p++) send_beat((p % 9) - 4, ref_ac(7, (p % 9) - 4), "R9 stalled stream");
    drain();
    stall_en = 0;
    repeat (3) @(negedge clk);

    // configuration changed after position 0: block keeps inter, q=3
    cfg_intra = 1'b0; cfg_q = 5'd3; cfg_dcs = 6'd8;
    send_beat(6, ref_ac(3, 6), "R11 pos0");
    cfg_intra = 1'b1; cfg_q = 5'd9; cfg_dcs = 6'd20;
    for (int p = 1; p < 64; p++) send_beat(p - 30, ref_ac(3, p - 30), "R11 held config");
    drain();

    // next block picks up the new configuration: intra DC with scaler 20
    send_beat(-3, -60, "R11/R7 new block dc");
    for (int p = 1; p < 64; p++) send_beat(2, ref_ac(9, 2), "R11 new step");
    drain();

    finish_up();
  end
endmodule